// File: doc/BRIEF.md
# Interrupt Summary and Pin Gating Unit

This unit gathers interrupt status for a controller with two interrupt sources. The bus-protocol side reports events into two sticky status registers. The DMA side reports events into one sticky status register. A separate one-shot "on-the-fly" event, raised by the script engine, sets its own flag. The unit combines these into summary flags and drives a single active-low interrupt pin. It also passes two live engine status inputs through to the host: FIFO flushing and engine running.

A host reaches the unit through a plain single-cycle register port. Reads return data combinationally in the cycle that `host_sel` is high. Writes take effect at the next clock edge. There is no back-pressure: every access completes in one cycle.

A synchronous-disable control gates the pin. If the pin is already asserted when the control is set, the pin stays asserted until every pending interrupt has been serviced. After that, later interrupts are kept off the pin until the control is cleared.

Register map (`host_addr`):

| Addr | Contents |
|------|----------|
| 0 | Summary: bit0 on-the-fly flag (write 1 to clear), bit1 bus summary, bit2 DMA summary |
| 1 | Control: bit0 disable (read/write), bit1 flushing, bit2 running (both read-only) |
| 2 | Bus status A |
| 3 | Bus status B |
| 4 | DMA status |

Top module: `irq_summary`

## Requirements
- R1: After reset, all source status bits, the on-the-fly flag and the disable bit are 0, and `irq_n` is 1.
- R2: A source status bit is set by a pulse on its event input. It stays set until a host read of its register (address 2, 3 or 4). That read returns the bit, and the bit reads 0 from the next cycle.
- R3: If an event arrives in the same cycle as a clearing read of its register, the bit is set after that cycle. The set takes priority over the clear.
- R4: The on-the-fly flag (address 0 bit0) is set by `fly_evt`. It is cleared only by a host write to address 0 with `host_wdata` bit0 = 1. A write with bit0 = 0 leaves the flag unchanged.
- R5: While the on-the-fly flag is set, reads of addresses 2, 3 and 4 return their contents but clear nothing.
- R6: Address 0 bit1 is 1 exactly when some bit of bus status A or B is set. Address 0 bit2 is 1 exactly when some DMA status bit is set. The two flags are independent and may both be 1.
- R7: With the disable bit at 0, `irq_n` is 0 exactly when the on-the-fly flag, the bus summary or the DMA summary is 1. The pin reflects the register state of the same cycle.
- R8: Address 1 bit1 shows `fifo_flushing` and bit2 shows `engine_running`. Host writes do not change them.
- R9: If the disable bit is set while `irq_n` is 1, `irq_n` stays 1 whatever events arrive, until the disable bit is cleared. Clearing it makes the pin follow R7 again.
- R10: If the disable bit is set while `irq_n` is 0, `irq_n` stays 0 until all of the on-the-fly flag, the bus summary and the DMA summary are 0. From then on it stays 1 while the disable bit remains set.
- R11: The disable bit (address 1 bit0) can be written and read back at any time, including while `engine_running` is 1.
- R12: Host writes to addresses 2, 3 and 4 have no effect on the status registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_evt_a | input | BUS_W | Event pulses for bus status A |
| bus_evt_b | input | BUS_W | Event pulses for bus status B |
| dma_evt | input | DMA_W | Event pulses for DMA status |
| fly_evt | input | 1 | On-the-fly interrupt event pulse |
| fifo_flushing | input | 1 | Live FIFO-flushing status |
| engine_running | input | 1 | Live engine-running status |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while host_sel is high |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench targets the following corner cases:

- **Event colliding with a clearing read.** A design that lets the clear win would silently lose that event.
- **Source reads while the on-the-fly flag is pending.** A design without the priority rule would wipe source bits before the flag is cleared.
- **Setting the disable bit while the pin is already asserted.** A design that masks at once would drop an interrupt in mid-service. A design that never re-blocks would pass later interrupts through the mask.
- **Zero-valued flag writes, writes to read-only fields and writes to source registers.** These catch a design that treats any write as a clear or as a store.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SUMMARY = 3'd0,
    REG_CTRL    = 3'd1,
    REG_BUS_A   = 3'd2,
    REG_BUS_B   = 3'd3,
    REG_DMA     = 3'd4
  } reg_addr_e;

  localparam int SUM_FLY_BIT   = 0;
  localparam int SUM_BUS_BIT   = 1;
  localparam int SUM_DMA_BIT   = 2;
  localparam int CTRL_DIS_BIT  = 0;
  localparam int CTRL_FLSH_BIT = 1;
  localparam int CTRL_RUN_BIT  = 2;
endpackage

// File: rtl/irqsum_sticky.sv
// Sticky status register: events set bits, a clear strobe empties it.
// A set in the same cycle as a clear survives.
module irqsum_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] q,
  output logic         any
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | evt;
  end

  assign any = |q;
endmodule

// File: rtl/irqsum_pin_gate.sv
// Pin gating with hold-over: an assertion that is already visible when
// the disable bit goes up is kept until the raw request falls.
module irqsum_pin_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_req,
  input  logic dis,
  output logic irq_n
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   hold_q <= 1'b0;
    else if (dis) hold_q <= hold_q & raw_req;
    else          hold_q <= raw_req;
  end

  assign irq_n = ~(raw_req & (~dis | hold_q));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irqsum_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DMA_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_evt_a,
  input  logic [BUS_W-1:0]  bus_evt_b,
  input  logic [DMA_W-1:0]  dma_evt,
  input  logic              fly_evt,
  input  logic              fifo_flushing,
  input  logic              engine_running,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_n
);
  localparam int NUM_SRC = 3;

  reg_addr_e  addr_e;
  logic       wr_en;
  logic       rd_en;
  logic       fly_q;
  logic       fly_clr;
  logic       dis_q;
  logic       bus_sum;
  logic       dma_sum;
  logic       raw_req;
  logic [NUM_SRC-1:0] src_rd;
  logic [NUM_SRC-1:0] src_any;
  logic [BUS_W-1:0]   src_a_q;
  logic [BUS_W-1:0]   src_b_q;
  logic [DMA_W-1:0]   src_d_q;
  logic       unused_wdata;

  assign addr_e       = reg_addr_e'(host_addr);
  assign wr_en        = host_sel & host_wr;
  assign rd_en        = host_sel & ~host_wr;
  assign unused_wdata = ^host_wdata;

  // Clearing reads are held off while the on-the-fly flag is pending.
  assign src_rd[0] = rd_en & ~fly_q & (addr_e == REG_BUS_A);
  assign src_rd[1] = rd_en & ~fly_q & (addr_e == REG_BUS_B);
  assign src_rd[2] = rd_en & ~fly_q & (addr_e == REG_DMA);

  irqsum_sticky #(.W(BUS_W)) u_src_a (
    .clk(clk), .rst_n(rst_n), .evt(bus_evt_a), .clr(src_rd[0]),
    .q(src_a_q), .any(src_any[0]));

  irqsum_sticky #(.W(BUS_W)) u_src_b (
    .clk(clk), .rst_n(rst_n), .evt(bus_evt_b), .clr(src_rd[1]),
    .q(src_b_q), .any(src_any[1]));

  irqsum_sticky #(.W(DMA_W)) u_src_d (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr(src_rd[2]),
    .q(src_d_q), .any(src_any[2]));

  assign bus_sum = src_any[0] | src_any[1];
  assign dma_sum = src_any[2];

  assign fly_clr = wr_en & (addr_e == REG_SUMMARY) & host_wdata[SUM_FLY_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fly_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      fly_q <= (fly_clr ? 1'b0 : fly_q) | fly_evt;
      if (wr_en && addr_e == REG_CTRL)
        dis_q <= host_wdata[CTRL_DIS_BIT];
    end
  end

  assign raw_req = fly_q | bus_sum | dma_sum;

  irqsum_pin_gate u_gate (
    .clk(clk), .rst_n(rst_n), .raw_req(raw_req), .dis(dis_q), .irq_n(irq_n));

  always_comb begin
    host_rdata = '0;
    if (host_sel) begin
      unique case (addr_e)
        REG_SUMMARY: begin
          host_rdata[SUM_FLY_BIT] = fly_q;
          host_rdata[SUM_BUS_BIT] = bus_sum;
          host_rdata[SUM_DMA_BIT] = dma_sum;
        end
        REG_CTRL: begin
          host_rdata[CTRL_DIS_BIT]  = dis_q;
          host_rdata[CTRL_FLSH_BIT] = fifo_flushing;
          host_rdata[CTRL_RUN_BIT]  = engine_running;
        end
        REG_BUS_A: host_rdata[BUS_W-1:0] = src_a_q;
        REG_BUS_B: host_rdata[BUS_W-1:0] = src_b_q;
        REG_DMA:   host_rdata[DMA_W-1:0] = src_d_q;
        default:   host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqsum_checker.sv
module irqsum_checker #(
  parameter int BUS_W  = 8,
  parameter int DMA_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic              fly_q,
  input logic              dis_q,
  input logic              bus_sum,
  input logic              dma_sum,
  input logic              fly_evt,
  input logic [BUS_W-1:0]  bus_evt_a,
  input logic [BUS_W-1:0]  src_a_q,
  input logic              host_sel,
  input logic              host_wr,
  input logic [2:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata
);
  // R7: pending request with gate open drives the pin low
  assert_pin_low_when_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_q && (fly_q || bus_sum || dma_sum)) |-> !irq_n);

  // R7: nothing pending means the pin is released
  assert_pin_high_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fly_q || bus_sum || dma_sum) |-> irq_n);

  // R9/R10: once released under disable, the pin stays released
  assert_blocked_stays_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && irq_n) |=> (!dis_q || irq_n));

  // R4: the flag survives any cycle without a clearing write
  assert_fly_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fly_q && !(host_sel && host_wr && host_addr == 3'd0 && host_wdata[0])) |=> fly_q);

  // R3: an event always lands, even against a clearing read
  assert_event_not_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_evt_a) |=> bus_sum);

  // R5: reads under a pending on-the-fly flag clear nothing
  assert_fly_blocks_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fly_q && host_sel && !host_wr && host_addr == 3'd2 && (|src_a_q)) |=> (|src_a_q));

  // R4: the event sets the flag
  assert_fly_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fly_evt |=> fly_q);
endmodule

bind irq_summary irqsum_checker #(.BUS_W(BUS_W), .DMA_W(DMA_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fly_q(fly_q), .dis_q(dis_q),
  .bus_sum(bus_sum), .dma_sum(dma_sum), .fly_evt(fly_evt), .bus_evt_a(bus_evt_a),
  .src_a_q(src_a_q), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata));

// File: tb/test_irq_summary.sv
`timescale 1ns/100ps
module test_irq_summary;
  localparam int BW = 8;
  localparam int DW = 8;
  localparam int XW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] bus_evt_a = '0, bus_evt_b = '0;
  logic [DW-1:0] dma_evt = '0;
  logic fly_evt = 1'b0, fifo_flushing = 1'b0, engine_running = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [XW-1:0] host_wdata = '0;
  logic [XW-1:0] host_rdata;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [BW-1:0] m_a, m_b;
  logic [DW-1:0] m_d;
  logic m_fly, m_dis, m_hold;

  always #2.5 clk = ~clk;

  irq_summary #(.BUS_W(BW), .DMA_W(DW), .DATA_W(XW)) i_irq_summary (
    .clk(clk), .rst_n(rst_n), .bus_evt_a(bus_evt_a), .bus_evt_b(bus_evt_b),
    .dma_evt(dma_evt), .fly_evt(fly_evt), .fifo_flushing(fifo_flushing),
    .engine_running(engine_running), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_n(irq_n));

  function automatic logic m_raw();
    return m_fly | (|m_a) | (|m_b) | (|m_d);
  endfunction

  function automatic logic m_pin_n();
    return ~(m_raw() & (~m_dis | m_hold));
  endfunction

  function automatic logic [XW-1:0] m_read(input logic [2:0] a);
    logic [XW-1:0] v = '0;
    case (a)
      3'd0: v[2:0] = {|m_d, (|m_a) | (|m_b), m_fly};
      3'd1: v[2:0] = {engine_running, fifo_flushing, m_dis};
      3'd2: v[BW-1:0] = m_a;
      3'd3: v[BW-1:0] = m_b;
      3'd4: v[DW-1:0] = m_d;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_update();
    logic rd = host_sel && !host_wr && !m_fly;
    logic wr = host_sel && host_wr;
    m_hold = m_dis ? (m_hold & m_raw()) : m_raw();
    m_a = ((rd && host_addr == 3'd2) ? '0 : m_a) | bus_evt_a;
    m_b = ((rd && host_addr == 3'd3) ? '0 : m_b) | bus_evt_b;
    m_d = ((rd && host_addr == 3'd4) ? '0 : m_d) | dma_evt;
    m_fly = ((wr && host_addr == 3'd0 && host_wdata[0]) ? 1'b0 : m_fly) | fly_evt;
    if (wr && host_addr == 3'd1) m_dis = host_wdata[0];
  endtask

  task automatic check(input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    bus_evt_a = '0; bus_evt_b = '0; dma_evt = '0; fly_evt = 1'b0;
    host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
  endtask

  // One cycle: check read data, advance a clock, update model, check pin.
  task automatic step(input string req);
    #1;
    if (host_sel && !host_wr) check({req, " rdata"}, host_rdata, m_read(host_addr));
    @(posedge clk);
    model_update();
    @(negedge clk);
    check({req, " irq_n R7/R9/R10"}, {7'd0, irq_n}, {7'd0, m_pin_n()});
    clear_inputs();
  endtask

  task automatic hread(input logic [2:0] a, input string req);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    step(req);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [XW-1:0] d, input string req);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_a = '0; m_b = '0; m_d = '0; m_fly = 0; m_dis = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    rst_n = 1'b1;
    hread(3'd0, "R1");
    hread(3'd1, "R1");
    hread(3'd2, "R1");

    // R2 sticky and read clear
    bus_evt_a = 8'h11; step("R2");
    check("R2 pin asserted", {7'd0, irq_n}, 8'd0);
    step("R2");
    hread(3'd2, "R2");
    hread(3'd2, "R2");
    check("R2 pin released", {7'd0, irq_n}, 8'd1);

    // R3 set wins over clearing read
    dma_evt = 8'h01; step("R3");
    host_sel = 1; host_addr = 3'd4; dma_evt = 8'h80; step("R3");
    hread(3'd4, "R3");
    check("R3 survived", m_d, 8'h00);

    // R6 both summaries together
    bus_evt_b = 8'h02; dma_evt = 8'h04; step("R6");
    hread(3'd0, "R6");
    hread(3'd3, "R6");
    hread(3'd0, "R6");
    hread(3'd4, "R6");

    // R4 and R5
    fly_evt = 1; bus_evt_a = 8'h40; step("R4");
    hwrite(3'd0, 8'hFE, "R4");
    hread(3'd0, "R4");
    hread(3'd2, "R5");
    hread(3'd2, "R5");
    check("R5 kept", m_a, 8'h40);
    hwrite(3'd0, 8'h01, "R4");
    hread(3'd0, "R4");
    hread(3'd2, "R5");
    hread(3'd2, "R5");

    // R12 writes to source registers ignored
    dma_evt = 8'h22; step("R12");
    hwrite(3'd4, 8'h00, "R12");
    hwrite(3'd2, 8'hFF, "R12");
    hread(3'd2, "R12");
    hread(3'd4, "R12");

    // R8 and R11 read-only status and disable under engine running
    fifo_flushing = 1; engine_running = 1;
    hwrite(3'd1, 8'hF9, "R11");
    hread(3'd1, "R8/R11");
    hwrite(3'd1, 8'h06, "R8");
    hread(3'd1, "R8");
    fifo_flushing = 0;
    hread(3'd1, "R8");
    engine_running = 0;

    // R9 disable while idle blocks new events
    hwrite(3'd1, 8'h01, "R9");
    bus_evt_a = 8'h01; fly_evt = 1; step("R9");
    check("R9 blocked", {7'd0, irq_n}, 8'd1);
    hwrite(3'd1, 8'h00, "R9");
    check("R9 reopened", {7'd0, irq_n}, 8'd0);
    hwrite(3'd0, 8'h01, "R9");
    hread(3'd2, "R9");

    // R10 disable while asserted: hold, then block
    dma_evt = 8'h08; step("R10");
    hwrite(3'd1, 8'h01, "R10");
    check("R10 held", {7'd0, irq_n}, 8'd0);
    step("R10");
    hread(3'd4, "R10");
    check("R10 released", {7'd0, irq_n}, 8'd1);
    bus_evt_b = 8'h10; step("R10");
    check("R10 reblocked", {7'd0, irq_n}, 8'd1);
    hwrite(3'd1, 8'h00, "R10");
    check("R10 reopen", {7'd0, irq_n}, 8'd0);
    hread(3'd3, "R10");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) bus_evt_a = 8'(1 << ($urandom % 8));
      if ($urandom % 8 == 0) bus_evt_b = 8'(1 << ($urandom % 8));
      if ($urandom % 6 == 0) dma_evt = 8'(1 << ($urandom % 8));
      if ($urandom % 20 == 0) fly_evt = 1;
      fifo_flushing = 1'($urandom);
      engine_running = 1'($urandom);
      if ($urandom % 2 == 0) begin
        host_sel = 1;
        host_wr = ($urandom % 4 == 0);
        host_addr = 3'($urandom % 6);
        host_wdata = 8'($urandom);
        if (host_addr == 3'd1 && host_wr && ($urandom % 3 != 0)) host_wdata[0] = 1'b0;
      end
      step("R2/R3/R4/R5/R6/R8/R12 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule